// File: doc/BRIEF.md
# SWD Host Transfer Engine

This block runs a single serial-wire debug transaction from the host side. A one-cycle `start` pulse launches it. The block then sends the 8-bit request header and releases the data line for the turnaround. It samples the 3-bit acknowledge. Depending on that acknowledge, it moves 32 data bits plus parity, performs the prescribed back-off, and drives idle clocks. When the transaction ends it reports a 4-bit result and, for reads, the captured word. Automatic retry and multi-register sequences belong to the layer above.

The serial clock runs at half the system clock. Each serial bit takes two system cycles: a low phase and then a high phase. A bit the host drives is presented when the low phase begins and is held through the high phase. A bit the target drives is sampled at the end of the low phase, just before the serial clock rises. Between transactions the serial clock is high and the line is driven high.

Top module: `swd_xfer_engine`

## Requirements
- R1: The header is driven LSB-first in this order: start (1), req[0] (port select), req[1] (read when 1), req[2] (A2), req[3] (A3), even parity of req[3:0], stop (0), park (1).
- R2: After the header the line is released (`swdioOe`=0) for cfgTurn+1 serial clocks. Then three acknowledge bits are sampled LSB-first. OK=3'b001, WAIT=3'b010, FAULT=3'b100.
- R3: On an OK read the block samples 32 data bits LSB-first, then one parity bit, then releases for a turnaround. `rdData` takes the sampled word on every read acknowledged OK, and `result` is 4'b0001.
- R4: On an OK read whose received parity bit differs from the even parity of the 32 data bits, `result` is 4'b1000.
- R5: On an OK write the block gives one turnaround, then drives `wrData` LSB-first, then the even parity of `wrData`.
- R6: After an OK transfer the block drives cfgIdle serial clocks with the line low (none when cfgIdle is 0), then returns the line high.
- R7: On WAIT or FAULT with cfgDataPhase=0, only a turnaround follows the acknowledge. `result` is {1'b0, ack}.
- R8: On WAIT or FAULT of a read with cfgDataPhase=1, 33 released clocks precede the turnaround.
- R9: On WAIT or FAULT of a write with cfgDataPhase=1, the turnaround is followed by 33 clocks with the line driven low.
- R10: Any other acknowledge is a protocol error. The block gives cfgTurn+1+33 released clocks and returns {1'b0, ack}. `rdData` is unchanged.
- R11: While busy, `swclk` toggles on every system clock. Driven line values change only as a low phase begins. When idle, `swclk`, `swdioOut` and `swdioOe` are all 1, including after reset.
- R12: `start` is ignored while busy. `done` is a one-cycle pulse in the first cycle with `busy` low, and `result` is valid from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a transaction (ignored while busy) |
| req | input | 4 | {A3, A2, read, port select} |
| wrData | input | DATA_W | Word to write |
| cfgTurn | input | TURN_W | Turnaround length minus one |
| cfgIdle | input | IDLE_W | Idle clocks after an OK transfer |
| cfgDataPhase | input | 1 | Run the dummy data phase on WAIT/FAULT |
| swdioIn | input | 1 | Data line as seen at the pad |
| swclk | output | 1 | Serial clock |
| swdioOut | output | 1 | Data line value to drive |
| swdioOe | output | 1 | Data line output enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| result | output | 4 | Acknowledge or parity error code |
| rdData | output | DATA_W | Last word read with OK acknowledge |

## Verification
From the ports, the hardest paths to reach are the ones the target steers: a corrupted read parity bit, WAIT/FAULT with and without the dummy data phase, and acknowledge values outside the three legal codes. The bench therefore contains a target model that counts serial bits. It drives chosen acknowledge bits, read data and a deliberately flipped parity bit into the exact low phase where the engine samples them. Each transaction's full line waveform (value and enable per bit) is recorded. It is then compared against a pattern the bench builds from the requirements.

// File: rtl/swd_xfer_pkg.sv
package swd_xfer_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_TRN1,
    ST_ACK,
    ST_RDATA,
    ST_TRN2,
    ST_WDATA,
    ST_IDLECYC,
    ST_DUMMYRD,
    ST_DUMMYWR,
    ST_BACKOFF
  } xferState_t;

  typedef struct packed {
    logic load;
    logic hdrAdv;
    logic wrAdv;
    logic ackSample;
    logic rxSample;
    logic finish;
  } dpStrobe_t;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam logic [3:0] RES_PARERR = 4'b1000;

endpackage

// File: rtl/swd_xfer_datapath.sv
module swd_xfer_datapath
  import swd_xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [3:0]        req,
  input  logic [DATA_W-1:0] wrData,
  input  logic              swdioIn,
  output logic              hdrBit,
  output logic              wrBit,
  output logic              ackOk,
  output logic              ackWaitFault,
  output logic              reqRead,
  output logic [3:0]        result,
  output logic [DATA_W-1:0] rdData
);

  localparam int HDR_W = 8;
  localparam int FRM_W = DATA_W + 1;

  logic [HDR_W-1:0] hdrShift;
  logic [FRM_W-1:0] wrShift;
  logic [FRM_W-1:0] rxShift;
  logic [2:0]       ackReg;
  logic [3:0]       reqReg;
  logic             rxParityBad;

  assign hdrBit       = hdrShift[0];
  assign wrBit        = wrShift[0];
  assign reqRead      = reqReg[1];
  assign ackOk        = (ackReg == ACK_OK);
  assign ackWaitFault = (ackReg == ACK_WAIT) || (ackReg == ACK_FAULT);
  assign rxParityBad  = ^rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrShift <= '1;
      wrShift  <= '0;
      reqReg   <= '0;
    end else if (strobe.load) begin
      reqReg   <= req;
      hdrShift <= {1'b1, 1'b0, ^req, req[3], req[2], req[1], req[0], 1'b1};
      wrShift  <= {^wrData, wrData};
    end else begin
      if (strobe.hdrAdv) hdrShift <= {1'b1, hdrShift[HDR_W-1:1]};
      if (strobe.wrAdv)  wrShift  <= {1'b0, wrShift[FRM_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackReg  <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.ackSample) ackReg  <= {swdioIn, ackReg[2:1]};
      if (strobe.rxSample)  rxShift <= {swdioIn, rxShift[FRM_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      rdData <= '0;
    end else if (strobe.finish) begin
      if (ackOk && reqRead && rxParityBad) result <= RES_PARERR;
      else                                 result <= {1'b0, ackReg};
      if (ackOk && reqRead) rdData <= rxShift[DATA_W-1:0];
    end
  end

  // R4: the parity error code appears only after a read acknowledged OK
  assert_parerr_read_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !(ackOk && reqRead)) |=> !result[3]);

  // R10: words are not captured when the transfer was not an OK read
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !(ackOk && reqRead)) |=> $stable(rdData));

endmodule

// File: rtl/swd_xfer_ctrl.sv
module swd_xfer_ctrl
  import swd_xfer_pkg::*;
#(
  parameter int TURN_W = 2,
  parameter int IDLE_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TURN_W-1:0] cfgTurn,
  input  logic [IDLE_W-1:0] cfgIdle,
  input  logic              cfgDataPhase,
  input  logic              ackOk,
  input  logic              ackWaitFault,
  input  logic              reqRead,
  input  logic              hdrBit,
  input  logic              wrBit,
  output dpStrobe_t         strobe,
  output logic              swclk,
  output logic              swdioOut,
  output logic              swdioOe,
  output logic              busy,
  output logic              done
);

  localparam int DW_CW = $clog2(DATA_W + 1);
  localparam int CW_A  = (IDLE_W > TURN_W) ? IDLE_W : TURN_W;
  localparam int CW_B  = (CW_A > DW_CW) ? CW_A : DW_CW;
  localparam int CNT_W = (CW_B > 3) ? CW_B : 3;
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(DATA_W);

  xferState_t        state, nxtState;
  logic [CNT_W-1:0]  cnt, nxtCnt;
  logic              phaseHigh;
  logic [TURN_W-1:0] turnReg;
  logic [IDLE_W-1:0] idleReg;
  logic              dpReg;
  logic              endOfBit, finish, goIdle;
  logic [CNT_W-1:0]  turnLast;

  assign busy     = (state != ST_IDLE);
  assign endOfBit = busy && phaseHigh;
  assign turnLast = CNT_W'(turnReg);

  always_comb begin
    nxtState = state;
    nxtCnt   = cnt;
    finish   = 1'b0;
    goIdle   = 1'b0;
    if (state == ST_IDLE) begin
      if (start) begin
        nxtState = ST_HDR;
        nxtCnt   = CNT_W'(7);
      end
    end else if (endOfBit) begin
      if (cnt != '0) begin
        nxtCnt = cnt - CNT_W'(1);
      end else begin
        unique case (state)
          ST_HDR: begin
            nxtState = ST_TRN1;
            nxtCnt   = turnLast;
          end
          ST_TRN1: begin
            nxtState = ST_ACK;
            nxtCnt   = CNT_W'(2);
          end
          ST_ACK: begin
            if (ackOk && reqRead) begin
              nxtState = ST_RDATA;
              nxtCnt   = FRAME_LAST;
            end else if (ackWaitFault && dpReg && reqRead) begin
              nxtState = ST_DUMMYRD;
              nxtCnt   = FRAME_LAST;
            end else begin
              nxtState = ST_TRN2;
              nxtCnt   = turnLast;
            end
          end
          ST_RDATA, ST_DUMMYRD: begin
            nxtState = ST_TRN2;
            nxtCnt   = turnLast;
          end
          ST_TRN2: begin
            if (ackOk && !reqRead) begin
              nxtState = ST_WDATA;
              nxtCnt   = FRAME_LAST;
            end else if (ackOk) begin
              goIdle = 1'b1;
            end else if (ackWaitFault && dpReg && !reqRead) begin
              nxtState = ST_DUMMYWR;
              nxtCnt   = FRAME_LAST;
            end else if (ackWaitFault) begin
              finish = 1'b1;
            end else begin
              nxtState = ST_BACKOFF;
              nxtCnt   = FRAME_LAST;
            end
          end
          ST_WDATA: goIdle = 1'b1;
          default:  finish = 1'b1;
        endcase
        if (goIdle) begin
          if (idleReg == '0) begin
            finish = 1'b1;
          end else begin
            nxtState = ST_IDLECYC;
            nxtCnt   = CNT_W'(idleReg) - CNT_W'(1);
          end
        end
        if (finish) begin
          nxtState = ST_IDLE;
          nxtCnt   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      phaseHigh <= 1'b0;
      turnReg   <= '0;
      idleReg   <= '0;
      dpReg     <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= nxtState;
      cnt       <= nxtCnt;
      phaseHigh <= busy ? ~phaseHigh : 1'b0;
      done      <= finish;
      if (!busy && start) begin
        turnReg <= cfgTurn;
        idleReg <= cfgIdle;
        dpReg   <= cfgDataPhase;
      end
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.load      = !busy && start;
    strobe.hdrAdv    = endOfBit && (state == ST_HDR);
    strobe.wrAdv     = endOfBit && (state == ST_WDATA);
    strobe.ackSample = busy && !phaseHigh && (state == ST_ACK);
    strobe.rxSample  = busy && !phaseHigh && (state == ST_RDATA);
    strobe.finish    = finish;
  end

  assign swclk = !busy || phaseHigh;

  always_comb begin
    unique case (state)
      ST_IDLE:               begin swdioOe = 1'b1; swdioOut = 1'b1;   end
      ST_HDR:                begin swdioOe = 1'b1; swdioOut = hdrBit; end
      ST_WDATA:              begin swdioOe = 1'b1; swdioOut = wrBit;  end
      ST_IDLECYC, ST_DUMMYWR: begin swdioOe = 1'b1; swdioOut = 1'b0;   end
      default:               begin swdioOe = 1'b0; swdioOut = 1'b1;   end
    endcase
  end

  // R11: the serial clock toggles every system cycle during a transaction
  assert_clk_toggle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (swclk != $past(swclk)));

  // R11: driven value and enable hold through the high phase
  assert_drive_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && swclk) |-> ($stable(swdioOut) && $stable(swdioOe)));

  // R12: done lasts one cycle and comes with busy low
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: line returns driven high at the end of a transaction
  assert_line_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (swdioOe && swdioOut && swclk));

endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
  import swd_xfer_pkg::*;
#(
  parameter int TURN_W = 2,
  parameter int IDLE_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        req,
  input  logic [DATA_W-1:0] wrData,
  input  logic [TURN_W-1:0] cfgTurn,
  input  logic [IDLE_W-1:0] cfgIdle,
  input  logic              cfgDataPhase,
  input  logic              swdioIn,
  output logic              swclk,
  output logic              swdioOut,
  output logic              swdioOe,
  output logic              busy,
  output logic              done,
  output logic [3:0]        result,
  output logic [DATA_W-1:0] rdData
);

  dpStrobe_t strobe;
  logic hdrBit, wrBit, ackOk, ackWaitFault, reqRead;

  swd_xfer_ctrl #(
    .TURN_W(TURN_W),
    .IDLE_W(IDLE_W),
    .DATA_W(DATA_W)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .cfgTurn      (cfgTurn),
    .cfgIdle      (cfgIdle),
    .cfgDataPhase (cfgDataPhase),
    .ackOk        (ackOk),
    .ackWaitFault (ackWaitFault),
    .reqRead      (reqRead),
    .hdrBit       (hdrBit),
    .wrBit        (wrBit),
    .strobe       (strobe),
    .swclk        (swclk),
    .swdioOut     (swdioOut),
    .swdioOe      (swdioOe),
    .busy         (busy),
    .done         (done)
  );

  swd_xfer_datapath #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .req          (req),
    .wrData       (wrData),
    .swdioIn      (swdioIn),
    .hdrBit       (hdrBit),
    .wrBit        (wrBit),
    .ackOk        (ackOk),
    .ackWaitFault (ackWaitFault),
    .reqRead      (reqRead),
    .result       (result),
    .rdData       (rdData)
  );

endmodule

// File: tb/swd_xfer_engine_tb.sv
module swd_xfer_engine_tb_top;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] wdata;
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        badPar;
    logic [1:0]  turn;
    logic [7:0]  idle;
    logic        dp;
    logic [3:0]  expRes;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{4'b0010, 32'h0,         3'b001, 32'h2BA01477, 1'b0, 2'd0, 8'd0, 1'b0, 4'b0001},
    '{4'b0101, 32'hA5C30F96,  3'b001, 32'h0,        1'b0, 2'd1, 8'd4, 1'b0, 4'b0001},
    '{4'b1011, 32'h0,         3'b001, 32'h00000001, 1'b1, 2'd2, 8'd2, 1'b0, 4'b1000},
    '{4'b0110, 32'h0,         3'b010, 32'hFFFFFFFF, 1'b0, 2'd0, 8'd3, 1'b0, 4'b0010},
    '{4'b1000, 32'h12345678,  3'b100, 32'h0,        1'b0, 2'd3, 8'd3, 1'b0, 4'b0100},
    '{4'b0011, 32'h0,         3'b010, 32'hDEADBEEF, 1'b0, 2'd1, 8'd1, 1'b1, 4'b0010},
    '{4'b1101, 32'hCAFEF00D,  3'b100, 32'h0,        1'b0, 2'd0, 8'd1, 1'b1, 4'b0100},
    '{4'b0010, 32'h0,         3'b111, 32'h55555555, 1'b0, 2'd1, 8'd2, 1'b1, 4'b0111},
    '{4'b0001, 32'h0F0F0F0F,  3'b000, 32'h0,        1'b0, 2'd0, 8'd2, 1'b0, 4'b0000},
    '{4'b0100, 32'hFFFFFFFF,  3'b001, 32'h0,        1'b0, 2'd0, 8'd0, 1'b0, 4'b0001}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [3:0] req = '0;
  logic [31:0] wrData = '0;
  logic [1:0] cfgTurn = '0;
  logic [7:0] cfgIdle = '0;
  logic cfgDataPhase = 1'b0;
  logic swdioIn = 1'b1;
  logic swclk, swdioOut, swdioOe, busy, done;
  logic [3:0] result;
  logic [31:0] rdData;

  always #10 clk = ~clk;

  swd_xfer_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .req(req), .wrData(wrData),
    .cfgTurn(cfgTurn), .cfgIdle(cfgIdle), .cfgDataPhase(cfgDataPhase),
    .swdioIn(swdioIn), .swclk(swclk), .swdioOut(swdioOut), .swdioOe(swdioOe),
    .busy(busy), .done(done), .result(result), .rdData(rdData)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // target model state and recorded waveform
  vec_t cur;
  logic prevClk = 1'b1;
  int bitCnt = 0;
  int busyCyc = 0;
  logic recOe [0:399];
  logic recOut [0:399];
  logic expOe [0:399];
  logic expOut [0:399];
  int expLen;

  function automatic logic tgtBit(input int idx);
    int t, a;
    t = int'(cur.turn) + 1;
    a = 8 + t;
    if (idx >= a && idx < a + 3) return cur.ack[idx - a];
    if (cur.ack == 3'b001 && cur.req[1] && idx >= a + 3 && idx < a + 36) begin
      if (idx - a - 3 < 32) return cur.rdata[idx - a - 3];
      return (^cur.rdata) ^ cur.badPar;
    end
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    if (busy) begin
      busyCyc++;
      if (!swclk && prevClk) swdioIn = tgtBit(bitCnt);
      if (swclk && !prevClk && bitCnt < 400) begin
        recOe[bitCnt]  = swdioOe;
        recOut[bitCnt] = swdioOut;
        bitCnt++;
      end
    end else begin
      swdioIn = 1'b1;
    end
    prevClk = swclk;
  end

  task automatic push(input logic oe, input logic val, input int n);
    for (int i = 0; i < n; i++) begin
      expOe[expLen]  = oe;
      expOut[expLen] = val;
      expLen++;
    end
  endtask

  // expected waveform built from R1, R2, R3, R5, R6, R7, R8, R9, R10
  task automatic buildExp(input vec_t v);
    int t;
    logic [32:0] w;
    t = int'(v.turn) + 1;
    expLen = 0;
    push(1, 1'b1, 1);
    for (int i = 0; i < 4; i++) push(1, v.req[i], 1);
    push(1, ^v.req, 1);
    push(1, 1'b0, 1);
    push(1, 1'b1, 1);
    push(0, 1'b1, t);
    push(0, 1'b1, 3);
    if (v.ack == 3'b001) begin
      if (v.req[1]) begin
        push(0, 1'b1, 33);
        push(0, 1'b1, t);
      end else begin
        push(0, 1'b1, t);
        w = {^v.wdata, v.wdata};
        for (int i = 0; i < 33; i++) push(1, w[i], 1);
      end
      push(1, 1'b0, int'(v.idle));
    end else if (v.ack == 3'b010 || v.ack == 3'b100) begin
      if (v.dp && v.req[1]) begin
        push(0, 1'b1, 33);
        push(0, 1'b1, t);
      end else if (v.dp) begin
        push(0, 1'b1, t);
        push(1, 1'b0, 33);
      end else begin
        push(0, 1'b1, t);
      end
    end else begin
      push(0, 1'b1, t);
      push(0, 1'b1, 33);
    end
  endtask

  function automatic string tagOf(input vec_t v);
    if (v.ack == 3'b001) return v.req[1] ? (v.badPar ? "R4" : "R3") : "R5";
    if (v.ack == 3'b010 || v.ack == 3'b100)
      return v.dp ? (v.req[1] ? "R8" : "R9") : "R7";
    return "R10";
  endfunction

  logic [31:0] lastRd = '0;

  task automatic runVec(input vec_t v, input bit intrude);
    int waitCyc;
    int mism;
    string tg;
    tg = tagOf(v);
    cur = v;
    buildExp(v);
    @(negedge clk);
    bitCnt = 0;
    busyCyc = 0;
    req = v.req;
    wrData = v.wdata;
    cfgTurn = v.turn;
    cfgIdle = v.idle;
    cfgDataPhase = v.dp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitCyc = 0;
    while (!done && waitCyc < 5000) begin
      @(negedge clk);
      waitCyc++;
      if (intrude && waitCyc == 6) begin
        req = 4'b1111;
        wrData = 32'h0;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk(done == 1'b1, {tg, " transaction completes"}, 64'(done), 64'd1);
    chk(result == v.expRes, {tg, " result code"}, 64'(result), 64'(v.expRes));
    chk(bitCnt == expLen, {tg, " serial bit count"}, 64'(bitCnt), 64'(expLen));
    chk(busyCyc == 2 * expLen, "R11 two system cycles per serial bit", 64'(busyCyc), 64'(2 * expLen));
    mism = -1;
    for (int i = 0; i < expLen && i < bitCnt; i++) begin
      if (mism < 0 && (recOe[i] !== expOe[i] || (expOe[i] && recOut[i] !== expOut[i])))
        mism = i;
    end
    chk(mism < 0, {"R1,R2,R6 ", tg, " line waveform first bad bit"}, 64'(mism), 64'hFFFF_FFFF_FFFF_FFFF);
    if (v.ack == 3'b001 && v.req[1]) lastRd = v.rdata;
    chk(rdData == lastRd, {tg, " rdData"}, 64'(rdData), 64'(lastRd));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R12 done is one cycle, no relaunch", {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    #(20ns * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: idle state after reset
    chk(swclk && swdioOut && swdioOe, "R11 idle line high after reset",
        {61'd0, swclk, swdioOut, swdioOe}, 64'd7);
    chk(!busy && !done && result == 4'd0, "R12 not busy after reset",
        {59'd0, busy, done, result}, 64'd0);

    for (int k = 0; k < NVEC; k++) runVec(VECS[k], 1'b0);

    // R12: a start pulse in mid-transaction must not disturb it
    runVec(VECS[0], 1'b1);
    repeat (10) @(negedge clk);
    chk(!busy && swclk, "R12 ignored start launched nothing", {62'd0, busy, swclk}, 64'd1);

    // R6: boundary of no idle clocks after an OK read, then a long idle run
    runVec('{4'b1110, 32'h0, 3'b001, 32'h80000000, 1'b0, 2'd3, 8'd0, 1'b1, 4'b0001}, 1'b0);
    runVec('{4'b0100, 32'h00000001, 3'b001, 32'h0, 1'b0, 2'd2, 8'd20, 1'b0, 4'b0001}, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule